// File: doc/BRIEF.md
# Boot Mode Stall Controller

This block sequences processor start-up after a synchronous active-low reset. On the first clock edge with reset released it captures a two-bit boot-mode select. It keeps the CPU stall output asserted until the boot path for that mode has completed, and then lets the CPU fetch from address zero. Memory loading and the CPU core are outside the block.

Three paths are supported:
- **Host-loaded boot.** An external host loads memory while the CPU is stalled, then sets a release flag.
- **Debugger-assisted boot.** A debugger request makes the block set the release flag itself and arm a breakpoint at address zero.
- **ROM-copy boot.** The block starts a copy engine and waits for its completion handshake.

The release flag is also a host-to-CPU interrupt source. The host port can only set it, and the CPU port can only clear it. A new interrupt is raised only while the CPU runs and only after the CPU has cleared the flag.

Top module: `boot_stall_ctrl`

## Requirements
- R1: Any clock edge sampled with rst_n low forces these outputs: cpu_stall_o=1, rel_flag_o=0, bp_arm_o=0, copy_start_o=0 and cpu_irq_o=0.
- R2: boot_mode_i is captured only on the first edge with rst_n high. The encoding is 00 host, 01 debugger, 10 ROM copy, and 11 host. Later changes of boot_mode_i have no effect until the next reset.
- R3: In host mode, cpu_stall_o stays high until the release flag is set. A host_set_i sampled at edge k makes rel_flag_o high after edge k and cpu_stall_o low after edge k+1.
- R4: In debugger and ROM modes, host_set_i still sets rel_flag_o but leaves cpu_stall_o high.
- R5: In debugger mode, a dbg_req_i sampled at an edge has three effects after that edge: cpu_stall_o drops, bp_arm_o rises, and rel_flag_o is set. bp_arm_o then stays high until reset, including after the CPU clears the flag.
- R6: In ROM mode, copy_start_o is high for exactly one cycle, right after the capture edge. cpu_stall_o stays high until copy_done_i is sampled and drops after that edge.
- R7: dbg_req_i is ignored outside debugger mode, and copy_done_i is ignored outside ROM mode. Neither one releases the stall.
- R8: rel_flag_o is set by host_set_i and cleared by cpu_clr_i. When both are sampled at the same edge, the flag ends up set.
- R9: cpu_irq_o pulses for one cycle after an edge with all three of these true: the CPU is running, host_set_i is high, and the flag is clear. A set while stalled, or while the flag is already set, raises no pulse.
- R10: Once released, cpu_stall_o stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode_i | input | 2 | Boot-mode select, captured at reset release |
| host_set_i | input | 1 | Host write of 1 to the release flag |
| cpu_clr_i | input | 1 | CPU clear of the release flag |
| dbg_req_i | input | 1 | Debugger start request |
| copy_done_i | input | 1 | Copy engine completion |
| cpu_stall_o | output | 1 | CPU held stalled while high |
| copy_start_o | output | 1 | One-cycle start pulse to the copy engine |
| bp_arm_o | output | 1 | Breakpoint at address zero armed |
| rel_flag_o | output | 1 | Current release/interrupt flag |
| cpu_irq_o | output | 1 | One-cycle CPU interrupt pulse |

## Verification
A wrong state shows at the ports in one of two ways. A stall may drop early, visible on the cycle after an event that belongs to another mode. Or a stall may never drop, visible on the cycle after the event that should have released it. A mis-captured mode shows on the first cycle after reset release, as a copy start pulse that is missing or unexpected. The flag and interrupt logic are checked cycle by cycle around set, clear and simultaneous set-and-clear, both while stalled and while running. A wrongly remembered flag appears as a missing or extra interrupt pulse one cycle later.

// File: rtl/boot_stall_pkg.sv
// Package: shared state and boot-mode encodings for the boot stall controller.
// Assumes: boot-mode field is two bits; code 11 is treated as host boot.
package boot_stall_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [2:0] {
        ST_RESET       = 3'd0,
        ST_STALL_HOST  = 3'd1,
        ST_STALL_DEBUG = 3'd2,
        ST_STALL_COPY  = 3'd3,
        ST_RUN         = 3'd4
    } boot_state_t;

    typedef enum logic [MODE_W-1:0] {
        MODE_HOST     = 2'b00,
        MODE_DEBUG    = 2'b01,
        MODE_ROM      = 2'b10,
        MODE_HOST_ALT = 2'b11
    } boot_mode_t;

endpackage

// File: rtl/boot_seq_fsm.sv
// Module: boot sequencing state machine.
// Captures the boot mode on the first released edge, walks one stall path
// and enters a terminal run state. Also drives the copy start pulse and the
// breakpoint arm. Assumes synchronous active-low reset and a registered flag input.
module boot_seq_fsm
    import boot_stall_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    boot_mode_i,
    input  logic                 flag_i,
    input  logic                 dbg_req_i,
    input  logic                 copy_done_i,
    output boot_state_t          state_o,
    output boot_mode_t           mode_o,
    output logic                 copy_start_o,
    output logic                 bp_arm_o,
    output logic                 dbg_set_o
);

    boot_state_t state_q, state_d;
    boot_mode_t  mode_q;
    logic        capture;

    assign capture   = (state_q == ST_RESET);
    assign dbg_set_o = (state_q == ST_STALL_DEBUG) && dbg_req_i;

    // Next-state selection per boot path.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET: begin
                case (boot_mode_t'(boot_mode_i))
                    MODE_DEBUG: state_d = ST_STALL_DEBUG;
                    MODE_ROM:   state_d = ST_STALL_COPY;
                    default:    state_d = ST_STALL_HOST;
                endcase
            end
            ST_STALL_HOST:  if (flag_i)      state_d = ST_RUN;
            ST_STALL_DEBUG: if (dbg_req_i)   state_d = ST_RUN;
            ST_STALL_COPY:  if (copy_done_i) state_d = ST_RUN;
            ST_RUN:         state_d = ST_RUN;
            default:        state_d = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Boot-mode capture on the first released edge only.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_HOST;
        else if (capture) mode_q <= boot_mode_t'(boot_mode_i);
    end

    // One-cycle copy start when entering the ROM copy path.
    always_ff @(posedge clk) begin
        if (!rst_n) copy_start_o <= 1'b0;
        else        copy_start_o <= capture && (state_d == ST_STALL_COPY);
    end

    // Breakpoint arm: set on debugger release, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         bp_arm_o <= 1'b0;
        else if (dbg_set_o) bp_arm_o <= 1'b1;
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;

    // R2: captured mode holds once past the capture edge
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RESET) |=> $stable(mode_q));

    // R10: run state is terminal
    assert_run_terminal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

    // R6: copy start is a single-cycle pulse
    assert_copy_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start_o |=> !copy_start_o);

    // R3: host path cannot leave stall without the flag
    assert_host_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL_HOST && !flag_i) |=> (state_q == ST_STALL_HOST));

    // R5: breakpoint is armed only once running
    assert_bp_when_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bp_arm_o |-> (state_q == ST_RUN));

endmodule

// File: rtl/release_flag.sv
// Module: host release / interrupt flag.
// Set-only from the host and the debugger auto-set, clear-only from the CPU;
// set wins over clear. Raises a one-cycle interrupt only for a set that
// arrives while the CPU runs and the flag is clear.
module release_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic host_set_i,
    input  logic auto_set_i,
    input  logic cpu_clr_i,
    input  logic run_i,
    output logic flag_o,
    output logic irq_o
);

    logic set_req;

    assign set_req = host_set_i || auto_set_i;

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_o <= 1'b0;
        else if (set_req)   flag_o <= 1'b1;
        else if (cpu_clr_i) flag_o <= 1'b0;
    end

    // Interrupt pulse for an accepted host set while running.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= run_i && host_set_i && !flag_o;
    end

    // R8: any set leaves the flag high on the next cycle
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag_o);

    // R9: an interrupt pulse always accompanies a set flag
    assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R9: interrupt pulse lasts one cycle
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

endmodule

// File: rtl/boot_stall_ctrl.sv
// Module: boot stall controller top.
// Joins the sequencing FSM and the release flag. Stall is high in every
// state except run. Assumes synchronous active-low reset on rst_n.
module boot_stall_ctrl
    import boot_stall_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] boot_mode_i,
    input  logic              host_set_i,
    input  logic              cpu_clr_i,
    input  logic              dbg_req_i,
    input  logic              copy_done_i,
    output logic              cpu_stall_o,
    output logic              copy_start_o,
    output logic              bp_arm_o,
    output logic              rel_flag_o,
    output logic              cpu_irq_o
);

    boot_state_t state;
    boot_mode_t  mode;
    logic        dbg_set;
    logic        running;

    assign running     = (state == ST_RUN);
    assign cpu_stall_o = !running;

    boot_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_mode_i  (boot_mode_i),
        .flag_i       (rel_flag_o),
        .dbg_req_i    (dbg_req_i),
        .copy_done_i  (copy_done_i),
        .state_o      (state),
        .mode_o       (mode),
        .copy_start_o (copy_start_o),
        .bp_arm_o     (bp_arm_o),
        .dbg_set_o    (dbg_set)
    );

    release_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_set_i (host_set_i),
        .auto_set_i (dbg_set),
        .cpu_clr_i  (cpu_clr_i),
        .run_i      (running),
        .flag_o     (rel_flag_o),
        .irq_o      (cpu_irq_o)
    );

    // R4: a stall drop in a non-host mode needs the mode's own event
    assert_mode_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_stall_o) && mode == MODE_ROM) |-> $past(copy_done_i));

    // R7: debugger release only comes from a debugger request
    assert_dbg_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_stall_o) && mode == MODE_DEBUG) |-> $past(dbg_req_i));

endmodule

// File: tb/boot_stall_ctrl_tb.sv
`timescale 1ns/1ps
module boot_stall_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] boot_mode_i = 2'b00;
    logic       host_set_i = 1'b0;
    logic       cpu_clr_i = 1'b0;
    logic       dbg_req_i = 1'b0;
    logic       copy_done_i = 1'b0;
    logic       cpu_stall_o, copy_start_o, bp_arm_o, rel_flag_o, cpu_irq_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    boot_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode_i),
        .host_set_i(host_set_i), .cpu_clr_i(cpu_clr_i),
        .dbg_req_i(dbg_req_i), .copy_done_i(copy_done_i),
        .cpu_stall_o(cpu_stall_o), .copy_start_o(copy_start_o),
        .bp_arm_o(bp_arm_o), .rel_flag_o(rel_flag_o), .cpu_irq_o(cpu_irq_o)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Advance one edge; inputs change and outputs are sampled 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Hold reset, check reset state, then release with the given mode.
    task automatic do_reset(input logic [1:0] mode);
        rst_n = 1'b0;
        host_set_i = 0; cpu_clr_i = 0; dbg_req_i = 0; copy_done_i = 0;
        boot_mode_i = mode;
        step(); step();
        chk("R1 stall in reset", cpu_stall_o, 1'b1);
        chk("R1 flag in reset", rel_flag_o, 1'b0);
        chk("R1 bp in reset", bp_arm_o, 1'b0);
        chk("R1 copy start in reset", copy_start_o, 1'b0);
        chk("R1 irq in reset", cpu_irq_o, 1'b0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_host();
        do_reset(2'b00);
        chk("R3 stall after release", cpu_stall_o, 1'b1);
        chk("R2 no copy start in host mode", copy_start_o, 1'b0);
        boot_mode_i = 2'b10;                       // late change, no effect
        step(); step();
        chk("R3 stall held without flag", cpu_stall_o, 1'b1);
        dbg_req_i = 1; step(); dbg_req_i = 0;
        chk("R7 dbg ignored in host mode", cpu_stall_o, 1'b1);
        copy_done_i = 1; step(); copy_done_i = 0;
        chk("R7 copy done ignored in host mode", cpu_stall_o, 1'b1);
        chk("R2 late mode change ignored", copy_start_o, 1'b0);
        host_set_i = 1; step(); host_set_i = 0;
        chk("R3 flag set", rel_flag_o, 1'b1);
        chk("R3 stall still high one cycle", cpu_stall_o, 1'b1);
        chk("R9 no irq while stalled", cpu_irq_o, 1'b0);
        step();
        chk("R3 stall released", cpu_stall_o, 1'b0);
        chk("R9 no irq after release", cpu_irq_o, 1'b0);
        host_set_i = 1; step(); host_set_i = 0;
        chk("R9 set ignored while flag set", cpu_irq_o, 1'b0);
        cpu_clr_i = 1; step(); cpu_clr_i = 0;
        chk("R8 cpu clear", rel_flag_o, 1'b0);
        host_set_i = 1; step(); host_set_i = 0;
        chk("R9 irq pulse", cpu_irq_o, 1'b1);
        chk("R8 set flag", rel_flag_o, 1'b1);
        step();
        chk("R9 irq one cycle", cpu_irq_o, 1'b0);
        cpu_clr_i = 1; step();
        host_set_i = 1; step(); host_set_i = 0; cpu_clr_i = 0;
        chk("R8 set wins over clear", rel_flag_o, 1'b1);
        step(); step();
        chk("R10 stall stays low", cpu_stall_o, 1'b0);
    endtask

    task automatic t_debug();
        do_reset(2'b01);
        chk("R5 stall after release", cpu_stall_o, 1'b1);
        copy_done_i = 1; step(); copy_done_i = 0;
        chk("R7 copy done ignored in debug mode", cpu_stall_o, 1'b1);
        chk("R5 flag clear before request", rel_flag_o, 1'b0);
        dbg_req_i = 1; step(); dbg_req_i = 0;
        chk("R5 stall released", cpu_stall_o, 1'b0);
        chk("R5 breakpoint armed", bp_arm_o, 1'b1);
        chk("R5 flag auto set", rel_flag_o, 1'b1);
        chk("R9 no irq on auto set", cpu_irq_o, 1'b0);
        cpu_clr_i = 1; step(); cpu_clr_i = 0;
        chk("R8 flag cleared", rel_flag_o, 1'b0);
        chk("R5 breakpoint held", bp_arm_o, 1'b1);
    endtask

    task automatic t_rom();
        do_reset(2'b10);
        chk("R6 copy start pulse", copy_start_o, 1'b1);
        chk("R6 stall during copy", cpu_stall_o, 1'b1);
        step();
        chk("R6 copy start one cycle", copy_start_o, 1'b0);
        host_set_i = 1; step(); host_set_i = 0;
        chk("R4 flag set in ROM mode", rel_flag_o, 1'b1);
        step();
        chk("R4 flag does not release ROM mode", cpu_stall_o, 1'b1);
        dbg_req_i = 1; step(); dbg_req_i = 0;
        chk("R7 dbg ignored in ROM mode", cpu_stall_o, 1'b1);
        chk("R7 no breakpoint in ROM mode", bp_arm_o, 1'b0);
        copy_done_i = 1; step(); copy_done_i = 0;
        chk("R6 release on copy done", cpu_stall_o, 1'b0);
    endtask

    task automatic t_alt_host();
        do_reset(2'b11);
        chk("R2 code 11 no copy start", copy_start_o, 1'b0);
        copy_done_i = 1; step(); copy_done_i = 0;
        chk("R2 code 11 copy done ignored", cpu_stall_o, 1'b1);
        host_set_i = 1; step(); host_set_i = 0; step();
        chk("R2 code 11 acts as host", cpu_stall_o, 1'b0);
        rst_n = 1'b0; step();
        chk("R1 reset from run restalls", cpu_stall_o, 1'b1);
    endtask

    initial begin
        t_host();
        t_debug();
        t_rom();
        t_alt_host();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule